// File: doc/BRIEF.md
# Two-Slot Instruction Decoder

The block takes a stream of 64-bit instruction words over a valid/ready handshake and turns each instruction into one decoded record. A plain word is cut into its immediate, offset, register-number and opcode fields, and the opcode is cut again into its operation code, operand-select bit and class. The output also carries a 64-bit constant and a set of error flags.

One opcode marks a wide constant load. That instruction spans two words. When the decoder sees that opcode, it keeps the first word and takes the next word as a companion word. It then emits a single record whose 64-bit constant joins the two 32-bit immediates. A companion word with stray nonzero fields is flagged. A wide opcode that arrives on the final word of a stream is reported as cut short. Register numbers above the legal range are flagged. Back-pressure on the output holds the record and stops intake.

Top module: `wide_instr_decoder`

## Requirements
- R1: An input word is split as imm = bits 63:32, offset = bits 31:16, src = bits 15:12, dst = bits 11:8, opcode = bits 7:0, and these appear on the matching output ports.
- R2: The opcode is split further: op_code = opcode bits 7:4, src_sel = bit 3, where 1 (opcode value 0x08) selects the source register as operand and 0 selects the immediate, and op_class = bits 2:0.
- R3: For a single-word instruction, out_imm64 is the 32-bit immediate sign-extended to 64 bits, and out_is_wide is 0.
- R4: A word with opcode equal to WIDE_OPCODE (default 0x18) that is not marked last produces no record. The next accepted word is its companion. The record is emitted on the cycle after the companion is accepted, with out_is_wide = 1, out_imm64 = {companion imm, first imm}, and every other field taken from the first word.
- R5: out_err_pseudo is 1 exactly when the companion word has a nonzero opcode, dst, src or offset field. It is never set on a record that is not a merged wide record.
- R6: out_err_reg is 1 when a register number exceeds MAX_REG (default 10). Both src and dst are checked for a single-word instruction. Only dst is checked for a wide one, because its src field is reused.
- R7: A wide opcode that arrives with in_last = 1 emits a record at once, with out_is_wide = 1, out_err_trunc = 1 and out_imm64 = {32'h0, imm}. The word after it is decoded as a fresh instruction.
- R8: While out_valid = 1 and out_ready = 0, the record stays stable and in_ready = 0. Otherwise in_ready = 1.
- R9: After reset out_valid = 0, in_ready = 1 and no wide instruction is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Decoder accepts a word |
| in_word | input | 64 | Instruction word |
| in_last | input | 1 | Word is the final one of its stream |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_imm64 | output | 64 | Constant (sign-extended, merged, or zero-padded) |
| out_offset | output | 16 | Offset field |
| out_src | output | 4 | Source register number |
| out_dst | output | 4 | Destination register number |
| out_opcode | output | 8 | Full opcode |
| out_op_code | output | 4 | Operation code part |
| out_src_sel | output | 1 | Operand select (1 = register) |
| out_op_class | output | 3 | Class part |
| out_is_wide | output | 1 | Record came from a wide instruction |
| out_err_reg | output | 1 | Register number out of range |
| out_err_pseudo | output | 1 | Companion word had nonzero fields |
| out_err_trunc | output | 1 | Wide instruction cut off by stream end |

## Verification
The pending flag for a wide instruction is the only state that spans words. If it is set wrongly, the very next record shows it: a plain word gets merged into a wide record, or a companion word surfaces as a record of its own. Either way the stream of records drifts against the expected list within one instruction. A faulty output register shows as a record that changes or is lost during a stall, or as a duplicate when in_ready does not drop, and this appears on the first cycle of back-pressure. The bench compares every record against a model that walks the same word sequence, and it checks record stability on every stalled cycle.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;
  localparam int IMM_W = 32;
  localparam int OFF_W = 16;
  localparam int REG_W = 4;
  localparam int OPC_W = 8;
  localparam int WORD_W = IMM_W + OFF_W + 2 * REG_W + OPC_W;
  localparam int CONST_W = 2 * IMM_W;

  typedef struct packed {
    logic [CONST_W-1:0] imm64;
    logic [OFF_W-1:0]   offset;
    logic [REG_W-1:0]   src;
    logic [REG_W-1:0]   dst;
    logic [OPC_W-1:0]   opcode;
    logic               is_wide;
    logic               err_reg;
    logic               err_pseudo;
    logic               err_trunc;
  } dec_rec_t;

  function automatic logic [CONST_W-1:0] merge_imm(input logic [IMM_W-1:0] hi,
                                                   input logic [IMM_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [CONST_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{IMM_W{v[IMM_W-1]}}, v};
  endfunction

  function automatic logic reg_bad(input logic [REG_W-1:0] r, input int max_reg);
    return int'(r) > max_reg;
  endfunction

  function automatic logic companion_bad(input logic [OFF_W-1:0] off,
                                         input logic [REG_W-1:0] s,
                                         input logic [REG_W-1:0] d,
                                         input logic [OPC_W-1:0] op);
    return (off != '0) || (s != '0) || (d != '0) || (op != '0);
  endfunction
endpackage

// File: rtl/instr_field_split.sv
module instr_field_split
  import instr_dec_pkg::*;
#(
  parameter int MAX_REG = 10
) (
  input  logic [WORD_W-1:0] word,
  output logic [IMM_W-1:0]  imm,
  output logic [OFF_W-1:0]  offset,
  output logic [REG_W-1:0]  src,
  output logic [REG_W-1:0]  dst,
  output logic [OPC_W-1:0]  opcode,
  output logic              src_bad,
  output logic              dst_bad,
  output logic              pseudo_bad
);
  localparam int OPC_LO = 0;
  localparam int DST_LO = OPC_LO + OPC_W;
  localparam int SRC_LO = DST_LO + REG_W;
  localparam int OFF_LO = SRC_LO + REG_W;
  localparam int IMM_LO = OFF_LO + OFF_W;

  always_comb begin
    imm        = word[IMM_LO +: IMM_W];
    offset     = word[OFF_LO +: OFF_W];
    src        = word[SRC_LO +: REG_W];
    dst        = word[DST_LO +: REG_W];
    opcode     = word[OPC_LO +: OPC_W];
    src_bad    = reg_bad(src, MAX_REG);
    dst_bad    = reg_bad(dst, MAX_REG);
    pseudo_bad = companion_bad(offset, src, dst, opcode);
  end
endmodule

// File: rtl/instr_pair_track.sv
module instr_pair_track
  import instr_dec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_first,
  input  logic             take_second,
  input  logic [IMM_W-1:0] c_imm,
  input  logic [OFF_W-1:0] c_off,
  input  logic [REG_W-1:0] c_src,
  input  logic [REG_W-1:0] c_dst,
  input  logic [OPC_W-1:0] c_op,
  input  logic             c_dst_bad,
  output logic             pending,
  output logic [IMM_W-1:0] h_imm,
  output logic [OFF_W-1:0] h_off,
  output logic [REG_W-1:0] h_src,
  output logic [REG_W-1:0] h_dst,
  output logic [OPC_W-1:0] h_op,
  output logic             h_dst_bad
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else if (take_first) begin
      pending <= 1'b1;
    end else if (take_second) begin
      pending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take_first) begin
      h_imm     <= c_imm;
      h_off     <= c_off;
      h_src     <= c_src;
      h_dst     <= c_dst;
      h_op      <= c_op;
      h_dst_bad <= c_dst_bad;
    end
  end

  a_r4_no_double_first: assert property (@(posedge clk) disable iff (!rst_n)
    take_first |-> !pending);
endmodule

// File: rtl/decode_out_reg.sv
module decode_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         take,
  output logic         valid,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
    end else if (take) begin
      valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) q <= d;
  end

  a_r8_hold_record: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !take |=> valid && $stable(q));
endmodule

// File: rtl/wide_instr_decoder.sv
module wide_instr_decoder
  import instr_dec_pkg::*;
#(
  parameter int          MAX_REG     = 10,
  parameter logic [7:0]  WIDE_OPCODE = 8'h18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [63:0]  in_word,
  input  logic         in_last,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [63:0]  out_imm64,
  output logic [15:0]  out_offset,
  output logic [3:0]   out_src,
  output logic [3:0]   out_dst,
  output logic [7:0]   out_opcode,
  output logic [3:0]   out_op_code,
  output logic         out_src_sel,
  output logic [2:0]   out_op_class,
  output logic         out_is_wide,
  output logic         out_err_reg,
  output logic         out_err_pseudo,
  output logic         out_err_trunc
);
  localparam int REC_W = $bits(dec_rec_t);

  logic [IMM_W-1:0] c_imm, h_imm;
  logic [OFF_W-1:0] c_off, h_off;
  logic [REG_W-1:0] c_src, c_dst, h_src, h_dst;
  logic [OPC_W-1:0] c_op, h_op;
  logic c_src_bad, c_dst_bad, c_pseudo_bad, h_dst_bad;
  logic pending;

  // named internal events
  logic accept, wide_now, first_half, second_half, trunc_evt, emit;
  dec_rec_t rec_d, rec_q;

  instr_field_split #(.MAX_REG(MAX_REG)) u_split (
    .word(in_word), .imm(c_imm), .offset(c_off), .src(c_src), .dst(c_dst),
    .opcode(c_op), .src_bad(c_src_bad), .dst_bad(c_dst_bad),
    .pseudo_bad(c_pseudo_bad)
  );

  assign in_ready    = !out_valid || out_ready;
  assign accept      = in_valid && in_ready;
  assign wide_now    = !pending && (c_op == WIDE_OPCODE);
  assign first_half  = accept && wide_now && !in_last;
  assign trunc_evt   = accept && wide_now && in_last;
  assign second_half = accept && pending;
  assign emit        = accept && !first_half;

  instr_pair_track u_pair (
    .clk(clk), .rst_n(rst_n), .take_first(first_half), .take_second(second_half),
    .c_imm(c_imm), .c_off(c_off), .c_src(c_src), .c_dst(c_dst), .c_op(c_op),
    .c_dst_bad(c_dst_bad), .pending(pending), .h_imm(h_imm), .h_off(h_off),
    .h_src(h_src), .h_dst(h_dst), .h_op(h_op), .h_dst_bad(h_dst_bad)
  );

  always_comb begin
    rec_d = '0;
    if (pending) begin
      rec_d.imm64      = merge_imm(c_imm, h_imm);
      rec_d.offset     = h_off;
      rec_d.src        = h_src;
      rec_d.dst        = h_dst;
      rec_d.opcode     = h_op;
      rec_d.is_wide    = 1'b1;
      rec_d.err_reg    = h_dst_bad;
      rec_d.err_pseudo = c_pseudo_bad;
    end else begin
      rec_d.offset  = c_off;
      rec_d.src     = c_src;
      rec_d.dst     = c_dst;
      rec_d.opcode  = c_op;
      if (wide_now) begin
        rec_d.imm64     = merge_imm('0, c_imm);
        rec_d.is_wide   = 1'b1;
        rec_d.err_reg   = c_dst_bad;
        rec_d.err_trunc = 1'b1;
      end else begin
        rec_d.imm64   = sext_imm(c_imm);
        rec_d.err_reg = c_src_bad || c_dst_bad;
      end
    end
  end

  decode_out_reg #(.W(REC_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(emit), .d(rec_d), .take(out_ready),
    .valid(out_valid), .q(rec_q)
  );

  assign out_imm64      = rec_q.imm64;
  assign out_offset     = rec_q.offset;
  assign out_src        = rec_q.src;
  assign out_dst        = rec_q.dst;
  assign out_opcode     = rec_q.opcode;
  assign out_op_code    = rec_q.opcode[7:4];
  assign out_src_sel    = rec_q.opcode[3];
  assign out_op_class   = rec_q.opcode[2:0];
  assign out_is_wide    = rec_q.is_wide;
  assign out_err_reg    = rec_q.err_reg;
  assign out_err_pseudo = rec_q.err_pseudo;
  assign out_err_trunc  = rec_q.err_trunc;

  a_r4_first_silent: assert property (@(posedge clk) disable iff (!rst_n)
    first_half |=> !out_valid);
  a_r4_merge_emits: assert property (@(posedge clk) disable iff (!rst_n)
    second_half |=> out_valid && out_is_wide && !out_err_trunc);
  a_r5_pseudo_only_wide: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err_pseudo |-> out_is_wide && !out_err_trunc);
  a_r7_trunc_record: assert property (@(posedge clk) disable iff (!rst_n)
    trunc_evt |=> out_valid && out_err_trunc && (out_imm64[63:32] == '0));
  a_r3_sign_extend: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_is_wide |-> out_imm64[63:32] == {32{out_imm64[31]}});
  a_r6_dst_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (int'(out_dst) > MAX_REG) |-> out_err_reg);
  a_r8_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !accept);
endmodule

// File: tb/sim_wide_instr_decoder.sv
module sim_wide_instr_decoder;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] WIDE = 8'h18;
  localparam int NRAND = 600;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, out_ready = 0;
  logic [63:0] in_word = '0;
  logic in_ready, out_valid;
  logic [63:0] out_imm64;
  logic [15:0] out_offset;
  logic [3:0] out_src, out_dst, out_op_code;
  logic [7:0] out_opcode;
  logic out_src_sel, out_is_wide, out_err_reg, out_err_pseudo, out_err_trunc;
  logic [2:0] out_op_class;

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_instr_decoder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_imm64(out_imm64), .out_offset(out_offset),
    .out_src(out_src), .out_dst(out_dst), .out_opcode(out_opcode),
    .out_op_code(out_op_code), .out_src_sel(out_src_sel),
    .out_op_class(out_op_class), .out_is_wide(out_is_wide),
    .out_err_reg(out_err_reg), .out_err_pseudo(out_err_pseudo),
    .out_err_trunc(out_err_trunc)
  );

  typedef struct packed {
    logic [63:0] imm64; logic [15:0] off; logic [3:0] src; logic [3:0] dst;
    logic [7:0] op; logic wide; logic ereg; logic epse; logic etru;
  } exp_t;

  logic [63:0] words[$];
  logic        lasts[$];
  exp_t        expq[$];
  int checks = 0, fails = 0;

  function automatic logic [63:0] mk(input logic [31:0] imm, input logic [15:0] off,
                                     input logic [3:0] s, input logic [3:0] d,
                                     input logic [7:0] op);
    return {imm, off, s, d, op};
  endfunction

  task automatic push(input logic [63:0] w, input logic l);
    words.push_back(w); lasts.push_back(l);
  endtask

  // bench model: walk the word list, build expected records
  task automatic build_expected();
    logic pend = 0;
    logic [63:0] h = '0;
    for (int i = 0; i < words.size(); i++) begin
      logic [63:0] w = words[i];
      exp_t e = '0;
      if (pend) begin
        e.imm64 = {w[63:32], h[63:32]}; e.off = h[31:16]; e.src = h[15:12];
        e.dst = h[11:8]; e.op = h[7:0]; e.wide = 1; e.ereg = h[11:8] > 4'd10;
        e.epse = (w[31:0] != 32'h0);
        expq.push_back(e); pend = 0;
      end else if (w[7:0] == WIDE && !lasts[i]) begin
        h = w; pend = 1;
      end else begin
        e.off = w[31:16]; e.src = w[15:12]; e.dst = w[11:8]; e.op = w[7:0];
        if (w[7:0] == WIDE) begin
          e.imm64 = {32'h0, w[63:32]}; e.wide = 1; e.etru = 1;
          e.ereg = w[11:8] > 4'd10;
        end else begin
          e.imm64 = {{32{w[63]}}, w[63:32]};
          e.ereg = (w[11:8] > 4'd10) || (w[15:12] > 4'd10);
        end
        expq.push_back(e);
      end
    end
  endtask

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic compare(input exp_t e);
    chk("R1 imm/offset", {out_imm64[31:0], 16'h0, out_offset},
        {e.imm64[31:0], 16'h0, e.off});
    chk("R1 regs/opcode", {out_src, out_dst, out_opcode}, {e.src, e.dst, e.op});
    chk("R2 opcode split", {out_op_code, out_src_sel, out_op_class},
        {e.op[7:4], e.op[3], e.op[2:0]});
    if (e.etru) chk("R7 trunc record", {out_imm64[63:32], out_err_trunc, out_is_wide},
                    {e.imm64[63:32], 1'b1, 1'b1});
    else if (e.wide) chk("R4 merged const", {out_imm64, out_is_wide, out_err_trunc},
                         {e.imm64, 1'b1, 1'b0});
    else chk("R3 sign extend", {out_imm64, out_is_wide, out_err_trunc},
             {e.imm64, 1'b0, 1'b0});
    chk("R5 pseudo flag", out_err_pseudo, e.epse);
    chk("R6 reg range", out_err_reg, e.ereg);
  endtask

  function automatic logic [127:0] bundle();
    return {out_valid, out_imm64, out_offset, out_src, out_dst, out_opcode,
            out_is_wide, out_err_reg, out_err_pseudo, out_err_trunc};
  endfunction

  initial begin
    int idx = 0, cyc = 0;
    logic hold = 0;
    logic [127:0] snap = '0;
    void'($urandom(32'h5eed));
    // directed corners
    push(mk(32'hFFFF_FFF0, 16'h0004, 4'd3, 4'd2, 8'h0F), 0);   // reg operand, negative imm
    push(mk(32'h0000_0123, 16'h0000, 4'd0, 4'd10, 8'h04), 0);  // imm operand, dst at limit
    push(mk(32'h1, 16'h0, 4'd11, 4'd1, 8'h0C), 0);            // src out of range
    push(mk(32'h89AB_CDEF, 16'h0, 4'd0, 4'd5, WIDE), 0);      // clean wide
    push(mk(32'h0123_4567, 16'h0, 4'd0, 4'd0, 8'h00), 0);
    push(mk(32'h1111_2222, 16'h0, 4'd1, 4'd12, WIDE), 0);     // wide, bad companion, dst bad
    push(mk(32'h3333_4444, 16'h0, 4'd0, 4'd0, 8'h01), 0);
    push(mk(32'h5555_6666, 16'h0, 4'd2, 4'd3, WIDE), 1);      // truncated
    push(mk(32'h7, 16'h8, 4'd15, 4'd15, WIDE), 0);            // wide: src not checked, dst bad
    push(mk(32'h9, 16'h0, 4'd0, 4'd0, 8'h00), 1);
    push(mk(32'h8000_0000, 16'hFFFF, 4'd0, 4'd0, 8'h00), 0);  // word after end: fresh
    for (int i = 0; i < NRAND; i++) begin
      int r = $urandom % 8;
      logic [3:0] s = ($urandom % 4 == 0) ? 4'($urandom) : 4'($urandom % 11);
      logic [3:0] d = ($urandom % 4 == 0) ? 4'($urandom) : 4'($urandom % 11);
      if (r < 2) begin
        push(mk($urandom, 16'h0, s, d, WIDE), ($urandom % 10) == 0);
        if (($urandom % 4) == 0)
          push(mk($urandom, 16'($urandom % 3), 4'($urandom % 2), 4'($urandom % 2),
                  8'($urandom % 2)), 0);
        else push(mk($urandom, 16'h0, 4'h0, 4'h0, 8'h00), ($urandom % 10) == 0);
      end else begin
        push(mk($urandom, 16'($urandom), s, d, 8'($urandom)), ($urandom % 12) == 0);
      end
    end
    push(mk(32'h42, 16'h0, 4'd1, 4'd1, 8'h07), 1);
    build_expected();

    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset out_valid", out_valid, 1'b0);
    rst_n = 1;
    @(negedge clk);
    chk("R9 idle ready", {out_valid, in_ready}, {1'b0, 1'b1});

    while ((idx < words.size() || expq.size() > 0) && cyc < 100000) begin
      @(negedge clk);
      cyc++;
      if (hold) begin
        chk("R8 stall stable", bundle(), snap);
        chk("R8 stall ready low", in_ready, 1'b0);
      end
      out_ready = ($urandom % 3) != 0;
      if (idx < words.size() && ($urandom % 5) != 0) begin
        in_valid = 1; in_word = words[idx]; in_last = lasts[idx];
      end else begin
        in_valid = 0; in_word = $urandom; in_last = 0;
      end
      #1;
      hold = out_valid && !out_ready;
      snap = bundle();
      if (out_valid && out_ready) begin
        if (expq.size() == 0) chk("R4 extra record", 1'b1, 1'b0);
        else begin
          compare(expq[0]);
          void'(expq.pop_front());
        end
      end
      chk("R8 ready rule", in_ready, !(out_valid && !out_ready));
      if (in_valid && in_ready) idx++;
    end
    if (cyc >= 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    in_valid = 0;
    repeat (3) @(negedge clk);
    chk("R4 no leftover record", out_valid, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule